// File: doc/BRIEF.md
# Occurrence-Counting Trigger Unit

This block decides when an on-chip logic analyzer should fire. On every clock cycle it compares two probe buses. The qualifying event is that the two buses are exactly equal. Each cycle in which the event is true is counted. The unit fires once the count reaches a programmable threshold, so a condition has to recur a set number of times before it counts as a trigger. A single match is not enough.

Counting is split into a chain of trigger levels, and only one level counts at a time. Each level has its own threshold and its own counting mode:

- **Consecutive mode:** the event must hold on back-to-back cycles.
- **Cumulative mode:** matches may be spread out over time.

A level hands over to the next one when it completes. The trigger fires when the last configured level completes. Software sets the level count, the per-level thresholds and the modes, then pulses `arm`. The block samples the configuration at that moment and keeps it until the next arm.

The probe buses are taken as a sample on every clock cycle. There is no valid/ready handshake and no back-pressure, because the unit can never stall and cannot drop a sample. `trig_pulse`, `triggered`, `active_level` and `cur_count` are plain status outputs.

Top module: `trig_seq_unit`

## Requirements
- R1: After reset, `trig_pulse`, `triggered`, `active_level` and `cur_count` are all 0.
- R2: The event for a cycle is true only when every bit of `probe_a` equals the matching bit of `probe_b`. A difference in any single bit, including the MSB, is a miss.
- R3: In cumulative mode (mode bit = 0), each matching cycle adds one to the active level's count. A missing cycle leaves the count unchanged.
- R4: In consecutive mode (mode bit = 1), a missing cycle clears the active level's count to 0.
- R5: `trig_pulse` is high for exactly one cycle. That cycle follows the clock edge at which the last level's count reaches its threshold. `triggered` rises at the same edge and stays high until the next arm.
- R6: Once the last level has completed, `cur_count` stays at that level's threshold, and further matching cycles have no effect.
- R7: An arm clears every level's count, `triggered` and `active_level`, and restarts the chain at level 0. A match during the arm cycle itself is not counted. Before the first arm, matching cycles are not counted.
- R8: A threshold value of 0 behaves as 1.
- R9: The level count, thresholds and modes are sampled on the arm cycle. Changing those inputs later has no effect until the next arm.
- R10: Level k+1 begins counting on the cycle after level k completes. A match in the completing cycle counts only for level k. `active_level` shows the index of the level that is counting, and `cur_count` shows that level's count.
- R11: A level count of 0 behaves as 1. A level count above NUM_LEVELS behaves as NUM_LEVELS.
- R12: Level k takes its threshold from `thresh[k*CNT_W +: CNT_W]` and its mode from `mode_sel[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Samples the configuration and restarts the chain |
| lvl_count | input | LVL_W | Number of levels in the chain (sampled at arm) |
| mode_sel | input | NUM_LEVELS | Per-level mode: 1 = consecutive, 0 = cumulative |
| thresh | input | NUM_LEVELS*CNT_W | Per-level thresholds, packed with level 0 in the LSBs |
| probe_a | input | DATA_W | First probe bus |
| probe_b | input | DATA_W | Second probe bus |
| trig_pulse | output | 1 | One-cycle pulse when the chain completes |
| triggered | output | 1 | Sticky flag, set when the chain completes and cleared by arm |
| active_level | output | LVL_W | Index of the level that is counting |
| cur_count | output | CNT_W | Count of the active level |

## Verification
The bench builds the unit with three levels, a 4-bit counter and 8-bit probes. With these values a full three-deep chain runs in a few cycles. The 3-bit level-count field can hold 7, which exercises the clamp above the level limit. The narrow counter keeps the saturation and zero-threshold cases short. Mixed-mode chains show how a consecutive-mode miss interacts with the hand-over between levels.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic {
    MODE_CUMUL  = 1'b0,
    MODE_CONSEC = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/trig_match.sv
module trig_match #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] probe_a,
  input  logic [DATA_W-1:0] probe_b,
  output logic              evt
);
  // full-width equality is the qualifying event
  assign evt = (probe_a == probe_b);
endmodule

// File: rtl/trig_level.sv
module trig_level
  import trig_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [CNT_W-1:0] cfg_thr,
  input  logic             cfg_mode,
  input  logic             active,
  input  logic             evt,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [CNT_W-1:0] thr_q;
  cnt_mode_e        mode_q;
  logic             done_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  // level completes in this cycle
  assign hit = active && !done_q && evt && (cnt_inc >= {1'b0, thr_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= CNT_W'(1);
      mode_q <= MODE_CUMUL;
      cnt    <= '0;
      done_q <= 1'b0;
    end else if (arm) begin
      thr_q  <= (cfg_thr == '0) ? CNT_W'(1) : cfg_thr;
      mode_q <= cnt_mode_e'(cfg_mode);
      cnt    <= '0;
      done_q <= 1'b0;
    end else if (active && !done_q) begin
      if (evt) begin
        if (hit) begin
          cnt    <= thr_q;
          done_q <= 1'b1;
        end else begin
          cnt <= cnt_inc[CNT_W-1:0];
        end
      end else if (mode_q == MODE_CONSEC) begin
        cnt <= '0;
      end
    end
  end

  // R6
  cnt_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= thr_q);

  // R6
  done_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !arm) |=> $stable(cnt));

  // R4
  consec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done_q && !evt && !arm && mode_q == MODE_CONSEC) |=> (cnt == '0));

  // R3
  cumul_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !evt && !arm && mode_q == MODE_CUMUL) |=> $stable(cnt));
endmodule

// File: rtl/trig_seq_ctrl.sv
module trig_seq_ctrl #(
  parameter int NUM_LEVELS = 10,
  parameter int LVL_W      = $clog2(NUM_LEVELS) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  arm,
  input  logic [LVL_W-1:0]      lvl_cfg,
  input  logic [NUM_LEVELS-1:0] hit,
  output logic [NUM_LEVELS-1:0] active,
  output logic [LVL_W-1:0]      stage,
  output logic                  trig_pulse,
  output logic                  triggered
);
  localparam logic [LVL_W-1:0] MAX_LVL = LVL_W'(NUM_LEVELS);

  logic             running;
  logic [LVL_W-1:0] last_q;
  logic [LVL_W-1:0] last_nx;
  logic             stage_hit;

  always_comb begin
    if (lvl_cfg == '0)          last_nx = '0;
    else if (lvl_cfg > MAX_LVL) last_nx = MAX_LVL - 1'b1;
    else                        last_nx = lvl_cfg - 1'b1;
  end

  for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_act
    assign active[k] = running && (stage == LVL_W'(k));
  end

  assign stage_hit = |(hit & active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running    <= 1'b0;
      stage      <= '0;
      last_q     <= '0;
      trig_pulse <= 1'b0;
      triggered  <= 1'b0;
    end else if (arm) begin
      running    <= 1'b1;
      stage      <= '0;
      last_q     <= last_nx;
      trig_pulse <= 1'b0;
      triggered  <= 1'b0;
    end else begin
      trig_pulse <= 1'b0;
      if (running && stage_hit) begin
        if (stage == last_q) begin
          running    <= 1'b0;
          trig_pulse <= 1'b1;
          triggered  <= 1'b1;
        end else begin
          stage <= stage + 1'b1;
        end
      end
    end
  end

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  // R5
  pulse_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> triggered);

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (triggered && !arm) |=> triggered);

  // R10
  one_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(active));

  // R11
  stage_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage < MAX_LVL);
endmodule

// File: rtl/trig_seq_unit.sv
module trig_seq_unit #(
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 8,
  parameter int NUM_LEVELS = 10,
  parameter int LVL_W      = $clog2(NUM_LEVELS) + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        arm,
  input  logic [LVL_W-1:0]            lvl_count,
  input  logic [NUM_LEVELS-1:0]       mode_sel,
  input  logic [NUM_LEVELS*CNT_W-1:0] thresh,
  input  logic [DATA_W-1:0]           probe_a,
  input  logic [DATA_W-1:0]           probe_b,
  output logic                        trig_pulse,
  output logic                        triggered,
  output logic [LVL_W-1:0]            active_level,
  output logic [CNT_W-1:0]            cur_count
);
  logic                  evt;
  logic [NUM_LEVELS-1:0] hit;
  logic [NUM_LEVELS-1:0] active;
  logic [CNT_W-1:0]      cnt_arr [NUM_LEVELS];

  trig_match #(.DATA_W(DATA_W)) u_match (
    .probe_a (probe_a),
    .probe_b (probe_b),
    .evt     (evt)
  );

  for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_lvl
    trig_level #(.CNT_W(CNT_W)) u_lvl (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (arm),
      .cfg_thr  (thresh[k*CNT_W +: CNT_W]),
      .cfg_mode (mode_sel[k]),
      .active   (active[k]),
      .evt      (evt),
      .cnt      (cnt_arr[k]),
      .hit      (hit[k])
    );
  end

  trig_seq_ctrl #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .lvl_cfg    (lvl_count),
    .hit        (hit),
    .active     (active),
    .stage      (active_level),
    .trig_pulse (trig_pulse),
    .triggered  (triggered)
  );

  always_comb begin
    cur_count = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (active_level == LVL_W'(i)) cur_count = cnt_arr[i];
    end
  end

  // R7
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (cur_count == '0 && !triggered && !trig_pulse && active_level == '0));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (!trig_pulse && !triggered && cur_count == '0));
endmodule

// File: tb/sim_trig_seq_unit.sv
module sim_trig_seq_unit;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam int NL = 3;
  localparam int LW = $clog2(NL) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arm = 1'b0;
  logic [LW-1:0] lvl_count = '0;
  logic [NL-1:0] mode_sel = '0;
  logic [NL*CW-1:0] thresh = '0;
  logic [DW-1:0] probe_a = 8'h01;
  logic [DW-1:0] probe_b = 8'h02;
  logic          trig_pulse, triggered;
  logic [LW-1:0] active_level;
  logic [CW-1:0] cur_count;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  trig_seq_unit #(.DATA_W(DW), .CNT_W(CW), .NUM_LEVELS(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .arm(arm), .lvl_count(lvl_count),
    .mode_sel(mode_sel), .thresh(thresh), .probe_a(probe_a),
    .probe_b(probe_b), .trig_pulse(trig_pulse), .triggered(triggered),
    .active_level(active_level), .cur_count(cur_count)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic state(input string req, input int p, input int t, input int lvl, input int c);
    check(req, "trig_pulse", int'(trig_pulse), p);
    check(req, "triggered", int'(triggered), t);
    check(req, "active_level", int'(active_level), lvl);
    check(req, "cur_count", int'(cur_count), c);
  endtask

  // one sample cycle; outputs checked on the following falling edge
  task automatic cyc_ab(input logic [DW-1:0] a, input logic [DW-1:0] b);
    probe_a = a; probe_b = b;
    @(negedge clk);
  endtask

  task automatic cyc(input bit m);
    if (m) cyc_ab(8'h5A, 8'h5A); else cyc_ab(8'h5A, 8'h3C);
  endtask

  task automatic do_arm(input int lv, input logic [NL-1:0] md, input logic [NL*CW-1:0] th,
                        input bit match_in_arm);
    lvl_count = LW'(lv); mode_sel = md; thresh = th; arm = 1'b1;
    if (match_in_arm) begin probe_a = 8'h11; probe_b = 8'h11; end
    else begin probe_a = 8'h11; probe_b = 8'h12; end
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic t_reset();
    state("R1", 0, 0, 0, 0);
    cyc(1); cyc(1);
    state("R7", 0, 0, 0, 0); // not armed: nothing counted
  endtask

  task automatic t_cumul();
    do_arm(1, 3'b000, {4'd0, 4'd0, 4'd3}, 0);
    cyc(1); state("R3", 0, 0, 0, 1);
    cyc(0); state("R3", 0, 0, 0, 1);
    cyc(1); state("R3", 0, 0, 0, 2);
    cyc(0); cyc(0); state("R3", 0, 0, 0, 2);
    cyc(1); state("R5", 1, 1, 0, 3);
    cyc(1); state("R5", 0, 1, 0, 3);
    cyc(1); cyc(0); state("R6", 0, 1, 0, 3);
  endtask

  task automatic t_consec();
    do_arm(1, 3'b001, {4'd0, 4'd0, 4'd3}, 0);
    cyc(1); cyc(1); state("R4", 0, 0, 0, 2);
    cyc(0); state("R4", 0, 0, 0, 0);
    cyc(1); cyc(1); state("R4", 0, 0, 0, 2);
    cyc(1); state("R5", 1, 1, 0, 3);
  endtask

  task automatic t_compare();
    do_arm(1, 3'b000, {4'd0, 4'd0, 4'd2}, 0);
    cyc_ab(8'h80, 8'h00); state("R2", 0, 0, 0, 0);
    cyc_ab(8'h7F, 8'h7E); state("R2", 0, 0, 0, 0);
    cyc_ab(8'hC3, 8'hC3); state("R2", 0, 0, 0, 1);
    cyc_ab(8'h00, 8'h00); state("R2", 1, 1, 0, 2);
  endtask

  task automatic t_thr_zero();
    do_arm(1, 3'b000, {4'd0, 4'd0, 4'd0}, 0);
    cyc(0); state("R8", 0, 0, 0, 0);
    cyc(1); state("R8", 1, 1, 0, 1);
  endtask

  task automatic t_cfg_hold();
    do_arm(1, 3'b001, {4'd0, 4'd0, 4'd2}, 0);
    mode_sel = 3'b000; thresh = {4'd15, 4'd15, 4'd15}; lvl_count = 3'd3;
    cyc(1); state("R9", 0, 0, 0, 1);
    cyc(0); state("R9", 0, 0, 0, 0); // consecutive mode kept
    cyc(1); cyc(1); state("R9", 1, 1, 0, 2);
  endtask

  task automatic t_chain();
    // level0 cumulative thr 2, level1 consecutive thr 3 (R12 packing)
    do_arm(2, 3'b010, {4'd9, 4'd3, 4'd2}, 0);
    cyc(1); cyc(0); state("R10", 0, 0, 0, 1);
    cyc(1); state("R10", 0, 0, 1, 0); // completing match not passed on
    cyc(1); state("R12", 0, 0, 1, 1);
    cyc(0); state("R12", 0, 0, 1, 0);
    cyc(1); cyc(1); state("R10", 0, 0, 1, 2);
    cyc(1); state("R10", 1, 1, 1, 3);
  endtask

  task automatic t_rearm();
    do_arm(1, 3'b000, {4'd0, 4'd0, 4'd2}, 1); // match during arm not counted
    state("R7", 0, 0, 0, 0);
    cyc(1); state("R7", 0, 0, 0, 1);
    cyc(1); state("R7", 1, 1, 0, 2);
  endtask

  task automatic t_lvl_clamp();
    do_arm(0, 3'b000, {4'd1, 4'd1, 4'd1}, 0);
    cyc(1); state("R11", 1, 1, 0, 1);
    do_arm(7, 3'b000, {4'd1, 4'd1, 4'd1}, 0);
    cyc(1); state("R11", 0, 0, 1, 0);
    cyc(1); state("R11", 0, 0, 2, 0);
    cyc(1); state("R11", 1, 1, 2, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cumul();
    t_consec();
    t_compare();
    t_thr_zero();
    t_cfg_hold();
    t_chain();
    t_rearm();
    t_lvl_clamp();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule